// File: doc/BRIEF.md
# Strap-Sampled Status LED Pin Controller

This block runs a small set of dual-purpose pads on an Ethernet PHY. While the hardware (or power-on) reset is held, every pad is an input. The board pulls it up or down, and that level is a configuration strap. When reset ends, the block captures each strap level. Together the captured bits form the PHY management address. From then on each pad is an output that drives a status LED.

Each pad shows one selectable link event. The events are link up, activity, transmit, receive, collision, speed mode and duplex. A pad lights its LED by driving the inverse of its own captured strap level. When it is idle it drives the strap level itself, so the external bias network is left undisturbed. Short-lived events (activity, transmit, receive, collision) are stretched to a programmable minimum on-time so that a single-cycle pulse is still visible. A captured address of zero tells the rest of the PHY to float its MII outputs. A software reset restores the event selections and clears the stretch timers. It never resamples the straps and never turns the pads back into inputs.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, every bit of `pin_oe` is 0 (all pads are inputs).
- R2: After `hw_rst_n` rises between clock edges, `pin_oe` stays 0 through the first SYNC_STAGES+1 rising edges. All bits become 1 on rising edge SYNC_STAGES+2. The strap is sampled from `pin_in` on edge SYNC_STAGES+1.
- R3: `phy_addr[i]` equals the level of `pin_in[i]` that was captured at release. Later changes on `pin_in` have no effect on `phy_addr` or on the idle pad levels.
- R4: `mii_tristate` is 1 exactly when the pads are outputs and the captured address is all zeros. Otherwise it is 0.
- R5: A pad with an asserted selected event drives the inverse of its captured strap. With no asserted event it drives its captured strap level.
- R6: The event select codes are 0 link, 1 activity, 2 transmit, 3 receive, 4 collision, 5 speed, 6 duplex, and 7 none. In `ev_in` the events sit at the bit positions equal to their codes. A write with `sel_we[i]` high loads `sel_code` into pad i's selector. After hardware reset pad 0 selects link and pad 1 selects activity. Other pads select link.
- R7: A pulse on activity, transmit, receive or collision keeps its pads asserted for max(`stretch_len`,1) cycles, counted from the pulse cycle. Link, speed and duplex are not stretched: they follow `ev_in` directly.
- R8: A clock edge with `soft_rst` high does several things. It leaves `pin_oe` and `phy_addr` unchanged. It returns every selector to its reset default and clears all stretch timers. It drives every pad to its idle (strap) level.
- R9: `pin_out` reflects the selected event state one rising edge after the event is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Active-low hardware / power-on reset, asynchronous assertion |
| soft_rst | input | 1 | Synchronous software reset, active high |
| pin_in | input | NUM_PINS | Pad input levels (strap sense) |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_out | output | NUM_PINS | Pad drive levels |
| ev_in | input | 7 | Link event levels, bit position = select code |
| stretch_len | input | STRETCH_W | Minimum on-time in cycles for pulse events |
| sel_we | input | NUM_PINS | Per-pad selector write enable |
| sel_code | input | 3 | Event select code written by `sel_we` |
| phy_addr | output | NUM_PINS | Captured strap address, bit i from pad i |
| mii_tristate | output | 1 | Request to float MII outputs (address zero) |

## Verification
The bench builds the block with SYNC_STAGES=3, so the release latency is longer than the minimum. That shows the output-enable timing follows the parameter rather than a fixed count. STRETCH_W=4 brings the largest stretch value (15) into reach, along with the zero case that falls back to one cycle. All four strap patterns are exercised. This covers both the tri-state address and the two opposite LED polarities on the same build.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;

   localparam int NUM_EVENTS = 7;
   localparam int SEL_W      = 3;

   localparam logic [SEL_W-1:0] SEL_LINK   = 3'd0;
   localparam logic [SEL_W-1:0] SEL_ACT    = 3'd1;
   localparam logic [SEL_W-1:0] SEL_TX     = 3'd2;
   localparam logic [SEL_W-1:0] SEL_RX     = 3'd3;
   localparam logic [SEL_W-1:0] SEL_COL    = 3'd4;
   localparam logic [SEL_W-1:0] SEL_SPEED  = 3'd5;
   localparam logic [SEL_W-1:0] SEL_DUPLEX = 3'd6;
   localparam logic [SEL_W-1:0] SEL_NONE   = 3'd7;

   // events that are brief and need a minimum visible on-time
   function automatic bit is_pulse_event(int idx);
      return (idx >= int'(SEL_ACT)) && (idx <= int'(SEL_COL));
   endfunction

   // default selector for a pad after hardware reset
   function automatic logic [SEL_W-1:0] default_sel(int pad);
      return (pad == 1) ? SEL_ACT : SEL_LINK;
   endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                hw_rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] strap_q,
   output logic                oe_q
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("strap_capture: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] rel_sync;
   logic                   captured;

   // release synchroniser: assertion is asynchronous, release is clocked
   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n) rel_sync <= '0;
      else           rel_sync <= {rel_sync[SYNC_STAGES-2:0], 1'b1};
   end

   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n) begin
         captured <= 1'b0;
         strap_q  <= '0;
         oe_q     <= 1'b0;
      end else begin
         if (rel_sync[SYNC_STAGES-1] && !captured) begin
            captured <= 1'b1;
            strap_q  <= pin_in;
         end
         oe_q <= captured;
      end
   end

   // R1: pads stay inputs whenever hardware reset is applied
   always_ff @(posedge clk) begin
      if (!hw_rst_n) begin
         p_inputs_in_reset_r1: assert (!oe_q)
            else $error("pad enabled during hardware reset");
      end
   end

   // R2: output enable rises only after the strap capture has happened
   p_oe_after_capture_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
      $rose(oe_q) |-> $past(captured));

   // R3: captured straps never move while pads are outputs
   p_strap_frozen_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (oe_q && $past(oe_q)) |-> $stable(strap_q));

   // R8: nothing but hardware reset returns pads to input mode
   p_oe_sticky_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
      $past(oe_q) |-> oe_q);

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int STRETCH_W = 8
) (
   input  logic                 clk,
   input  logic                 hw_rst_n,
   input  logic                 clr,
   input  logic [STRETCH_W-1:0] len,
   input  logic                 ev,
   output logic                 stretched
);

   if (STRETCH_W < 1) begin : g_bad_w
      $error("led_stretch: STRETCH_W must be positive");
   end

   logic [STRETCH_W-1:0] remain;
   logic [STRETCH_W-1:0] load_val;

   assign load_val  = (len == '0) ? '0 : len - 1'b1;
   assign stretched = !clr && (ev || (remain != '0));

   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)          remain <= '0;
      else if (clr)           remain <= '0;
      else if (ev)            remain <= load_val;
      else if (remain != '0)  remain <= remain - 1'b1;
   end

   // R7: a pulse with a stretch above one keeps the output high next cycle
   p_min_on_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (ev && !clr && (len > 1)) |=> (stretched || clr));

endmodule

// File: rtl/strap_pin.sv
module strap_pin
   import strap_led_pkg::*;
#(
   parameter logic [SEL_W-1:0] DEF_SEL = SEL_LINK
) (
   input  logic                  clk,
   input  logic                  hw_rst_n,
   input  logic                  soft_rst,
   input  logic                  strap,
   input  logic [NUM_EVENTS-1:0] cond,
   input  logic                  sel_we,
   input  logic [SEL_W-1:0]      sel_code,
   output logic                  pad_out
);

   logic [SEL_W-1:0] sel_q;
   logic [7:0]       cond_ext;
   logic             active;

   assign cond_ext = {1'b0, cond};   // code 7 reads as never asserted
   assign active   = cond_ext[sel_q];

   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)    sel_q <= DEF_SEL;
      else if (soft_rst) sel_q <= DEF_SEL;
      else if (sel_we)   sel_q <= sel_code;
   end

   // asserted level is the inverse of the strap, idle level equals it
   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)     pad_out <= 1'b0;
      else if (soft_rst) pad_out <= strap;
      else               pad_out <= strap ^ active;
   end

   // R8: software reset leaves the pad at its idle level
   p_soft_idle_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
      soft_rst |=> (pad_out == $past(strap)));

   // R8: software reset restores the default event selection
   p_soft_default_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
      soft_rst |=> (sel_q == DEF_SEL));

   // R5: with the "none" code the pad never leaves its idle level
   p_none_idle_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (sel_q == SEL_NONE && !sel_we && !soft_rst) |=> (pad_out == $past(strap)));

endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
   import strap_led_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STRETCH_W   = 16
) (
   input  logic                  clk,
   input  logic                  hw_rst_n,
   input  logic                  soft_rst,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   pin_out,
   input  logic [NUM_EVENTS-1:0] ev_in,
   input  logic [STRETCH_W-1:0]  stretch_len,
   input  logic [NUM_PINS-1:0]   sel_we,
   input  logic [SEL_W-1:0]      sel_code,
   output logic [NUM_PINS-1:0]   phy_addr,
   output logic                  mii_tristate
);

   if (NUM_PINS < 1 || NUM_PINS > 5) begin : g_bad_pins
      $error("strap_led_ctrl: NUM_PINS must be 1..5");
   end

   logic [NUM_PINS-1:0]   strap_q;
   logic                  oe_q;
   logic [NUM_EVENTS-1:0] cond;

   strap_capture #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk      (clk),
      .hw_rst_n (hw_rst_n),
      .pin_in   (pin_in),
      .strap_q  (strap_q),
      .oe_q     (oe_q)
   );

   // shared event conditioning: one stretcher per brief event
   for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_ev
      if (is_pulse_event(e)) begin : g_str
         led_stretch #(.STRETCH_W(STRETCH_W)) u_str (
            .clk       (clk),
            .hw_rst_n  (hw_rst_n),
            .clr       (soft_rst),
            .len       (stretch_len),
            .ev        (ev_in[e]),
            .stretched (cond[e])
         );
      end else begin : g_lvl
         assign cond[e] = ev_in[e];
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      strap_pin #(.DEF_SEL(default_sel(p))) u_pad (
         .clk      (clk),
         .hw_rst_n (hw_rst_n),
         .soft_rst (soft_rst),
         .strap    (strap_q[p]),
         .cond     (cond),
         .sel_we   (sel_we[p]),
         .sel_code (sel_code),
         .pad_out  (pin_out[p])
      );
   end

   assign pin_oe       = {NUM_PINS{oe_q}};
   assign phy_addr     = strap_q;
   assign mii_tristate = oe_q && (strap_q == '0);

   // R4: once decided, the tri-state request holds until hardware reset
   p_tristate_steady_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (oe_q && $past(oe_q)) |-> $stable(mii_tristate));

   // R3: the address does not follow the pads after capture
   p_addr_steady_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
      $past(oe_q) |-> $stable(phy_addr));

endmodule

// File: tb/strap_led_ctrl_test.sv
`timescale 1ns/1ps
module strap_led_ctrl_test;

   localparam int NP   = 2;
   localparam int SYNC = 3;
   localparam int SW   = 4;

   logic          clk = 1'b0;
   logic          hw_rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_oe, pin_out, phy_addr;
   logic [6:0]    ev_in = '0;
   logic [SW-1:0] stretch_len = '0;
   logic [NP-1:0] sel_we = '0;
   logic [2:0]    sel_code = '0;
   logic          mii_tristate;

   int checks = 0;
   int errors = 0;
   logic [NP-1:0] strap_now = '0;

   always #10 clk = ~clk;

   strap_led_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(SYNC), .STRETCH_W(SW)) uut (
      .clk(clk), .hw_rst_n(hw_rst_n), .soft_rst(soft_rst), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .ev_in(ev_in),
      .stretch_len(stretch_len), .sel_we(sel_we), .sel_code(sel_code),
      .phy_addr(phy_addr), .mii_tristate(mii_tristate));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edge_s();
      @(posedge clk); #2;
   endtask

   // R1 R2 R3 R4 R5: hardware reset with a given strap pattern
   task automatic t_hw_reset(input logic [NP-1:0] s);
      @(negedge clk);
      hw_rst_n = 1'b0; pin_in = s; ev_in = '0; soft_rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(pin_oe == '0, "R1 oe low in reset", pin_oe, 0);
      hw_rst_n = 1'b1;
      for (int k = 0; k < SYNC + 1; k++) edge_s();
      chk(pin_oe == '0, "R2 oe still low", pin_oe, 0);
      edge_s();
      chk(pin_oe == '1, "R2 oe high", pin_oe, 3);
      strap_now = s;
      @(negedge clk); pin_in = ~s;
      repeat (2) edge_s();
      chk(phy_addr == s, "R3 address", phy_addr, s);
      chk(pin_out == s, "R3 idle level ignores pads", pin_out, s);
      chk(mii_tristate == (s == '0), "R4 tristate", mii_tristate, s == '0);
   endtask

   task automatic write_sel(input int pad, input logic [2:0] code);
      @(negedge clk); sel_we = '0; sel_we[pad] = 1'b1; sel_code = code;
      @(negedge clk); sel_we = '0;
   endtask

   // count cycles a pad shows asserted after a one-cycle pulse on event e
   task automatic t_pulse(input int e, input int pad, input int len, input int exp);
      int cnt = 0;
      @(negedge clk); stretch_len = SW'(len); ev_in[e] = 1'b1;
      @(negedge clk); ev_in[e] = 1'b0;
      // first asserting edge already passed at this negedge
      if (pin_out[pad] != strap_now[pad]) cnt++;
      for (int k = 0; k < 18; k++) begin
         edge_s();
         if (pin_out[pad] != strap_now[pad]) cnt++;
      end
      chk(cnt == exp, "R7 stretch length", cnt, exp);
   endtask

   task automatic t_level_events();
      // R5 R9: link on pad 0 (strapped high -> asserted low)
      @(negedge clk); ev_in[0] = 1'b1;
      chk(pin_out[0] == strap_now[0], "R9 no change before edge", pin_out[0], strap_now[0]);
      edge_s();
      chk(pin_out[0] == !strap_now[0], "R5 R9 link asserted", pin_out[0], !strap_now[0]);
      @(negedge clk); ev_in[0] = 1'b0;
      edge_s();
      chk(pin_out[0] == strap_now[0], "R5 link released", pin_out[0], strap_now[0]);
      // R7: speed is a level event on pad 1, no stretch
      write_sel(1, 3'd5);
      @(negedge clk); stretch_len = 4'd9; ev_in[5] = 1'b1;
      edge_s();
      chk(pin_out[1] == !strap_now[1], "R7 speed asserted", pin_out[1], !strap_now[1]);
      @(negedge clk); ev_in[5] = 1'b0;
      edge_s();
      chk(pin_out[1] == strap_now[1], "R7 speed unstretched", pin_out[1], strap_now[1]);
   endtask

   task automatic t_select();
      // R6: receive on pad 0, activity pad 1 ignores it
      write_sel(1, 3'd1);
      write_sel(0, 3'd3);
      t_pulse(3, 0, 4, 4);
      @(negedge clk); ev_in[3] = 1'b1;
      edge_s();
      chk(pin_out[1] == strap_now[1], "R6 unselected pad idle", pin_out[1], strap_now[1]);
      @(negedge clk); ev_in[3] = 1'b0;
      repeat (6) edge_s();
      // R6: code 7 never asserts
      write_sel(0, 3'd7);
      @(negedge clk); ev_in = 7'h7F;
      repeat (2) edge_s();
      chk(pin_out[0] == strap_now[0], "R6 none code idle", pin_out[0], strap_now[0]);
      @(negedge clk); ev_in = '0;
      repeat (18) edge_s();
   endtask

   task automatic t_soft_reset();
      write_sel(0, 3'd2);
      @(negedge clk); ev_in[0] = 1'b1; stretch_len = 4'd15; ev_in[1] = 1'b1;
      @(negedge clk); ev_in[1] = 1'b0;
      chk(pin_out[1] == !strap_now[1], "R7 activity lit", pin_out[1], !strap_now[1]);
      soft_rst = 1'b1;
      edge_s();
      chk(pin_out == strap_now, "R8 idle during soft reset", pin_out, strap_now);
      chk(pin_oe == '1, "R8 oe held", pin_oe, 3);
      chk(phy_addr == strap_now, "R8 address held", phy_addr, strap_now);
      @(negedge clk); soft_rst = 1'b0;
      edge_s();
      chk(pin_out[0] == !strap_now[0], "R8 pad0 back to link", pin_out[0], !strap_now[0]);
      chk(pin_out[1] == strap_now[1], "R8 stretch cleared", pin_out[1], strap_now[1]);
      @(negedge clk); ev_in = '0;
      edge_s();
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_hw_reset(2'b00);
      t_hw_reset(2'b10);
      t_hw_reset(2'b11);
      t_hw_reset(2'b01);
      // defaults: pad 0 link, pad 1 activity (R6)
      t_pulse(1, 1, 5, 5);
      t_pulse(1, 1, 0, 1);
      t_pulse(1, 1, 15, 15);
      t_pulse(1, 0, 15, 0);
      t_level_events();
      t_select();
      t_soft_reset();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule